// File: doc/BRIEF.md
# Light-Load Mode Supervisor

This block decides when a digital power-factor-correction controller runs in its light-load regime. Each time a new input-power sample arrives with its strobe, the sample is compared against a programmable low-power threshold. A sample below the threshold puts the controller into light load. Only a sample above the threshold plus a programmable hysteresis band brings it back to normal operation. Samples inside the band leave the current mode unchanged.

Three outputs follow the light-load decision, and each has its own enable bit. The low-frequency select switches the switching-frequency word to the programmed light-load value. The phase-shed signal tells the PWM stage to turn off one of its outputs. Both of these act in the cycle after the deciding sample. The current-loop filter select enters light load only after a number of line-cycle pulses (four by default) have been counted while power stays below the threshold. It leaves light load in the cycle after a sample rises above the hysteresis band. PWM generation and the filter itself are handled elsewhere.

Top module: `llm_supervisor`

## Requirements
- R1: After reset, `low_freq_sel`, `phase_shed` and `filt_light` are 0, `freq_word` equals `f_norm`, and the line-cycle count is zero.
- R2: A strobed sample (`pwr_valid`=1) strictly below `pth` puts the block into light load from the next cycle on.
- R3: A strobed sample strictly above `pth`+`hyst` returns the block to normal load from the next cycle on. Samples from `pth` up to and including `pth`+`hyst` hold the present mode. A sample with `pwr_valid`=0 has no effect.
- R4: With `feat_en[3]`=1 in light load, `low_freq_sel`=1 and `freq_word`=`f_low`. In every other case `low_freq_sel`=0 and `freq_word`=`f_norm`.
- R5: `phase_shed` is 1 exactly when `feat_en[4]`=1 and the block is in light load.
- R6: The block counts `line_tick` pulses while the most recent strobed sample was below `pth`. A strobed sample at or above `pth` clears the count, and the count saturates at QUAL_CYCLES (default 4). The filter state enters light load one cycle after the count reaches QUAL_CYCLES, and `filt_light` is 1 when that state is set and `feat_en[5]`=1.
- R7: A strobed sample above `pth`+`hyst` clears the filter state in the next cycle, with no line-cycle delay. A sample inside the band does not clear it.
- R8: Clearing an enable bit forces its output to the normal-mode value at once. The mode decision and the line-cycle count keep running underneath, so setting the bit again shows the current state.
- R9: The value `pth`+`hyst` is formed one bit wider than the sample, so a sum beyond the sample range never wraps. In that case no sample can end light load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_valid | input | 1 | Strobe: `pwr_sample` holds a new power value |
| pwr_sample | input | PW | Input power sample, unsigned |
| line_tick | input | 1 | One-cycle pulse per completed line cycle |
| feat_en | input | 3 (bits 5:3) | Enables: bit 3 frequency, bit 4 phase shed, bit 5 filter |
| pth | input | PW | Low-power threshold |
| hyst | input | PW | Hysteresis added to the threshold for exit |
| f_norm | input | FW | Normal switching-frequency word |
| f_low | input | FW | Light-load switching-frequency word |
| low_freq_sel | output | 1 | 1 when the light-load frequency is selected |
| phase_shed | output | 1 | 1 when one PWM output is to be disabled |
| filt_light | output | 1 | 1 when the light-load current filter is selected |
| freq_word | output | FW | Selected switching-frequency word |

## Verification
Power samples walk down through the threshold, sit inside the hysteresis band, land exactly on `pth` and on `pth`+`hyst`, and then rise above the band. These steps separate a strict comparison from an inclusive one and show whether the mode is held inside the band. Line-cycle pulses are sent in runs of three, four and more, and some runs are broken by an in-band sample. This shows whether the filter waits for an unbroken run, counts partial runs, or fails to saturate. A pulse and a strobe in the same cycle test which one takes priority. Enable bits are toggled while in light load, strobes are deasserted around out-of-range samples, and a threshold-plus-hysteresis sum that overflows is applied, to tell gating, strobe qualification and wide-sum handling apart.

// File: rtl/llm_pkg.sv
package llm_pkg;

    // Enable-bit positions inside the feature-enable field
    localparam int EN_FREQ = 3;
    localparam int EN_SHED = 4;
    localparam int EN_FILT = 5;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LIGHT  = 1'b1
    } load_mode_e;

    // Strobe-qualified comparison results for one power sample
    typedef struct packed {
        logic under;       // sample < threshold
        logic at_or_over;  // sample >= threshold
        logic above_band;  // sample > threshold + hysteresis
    } pwr_cmp_t;

    function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

endpackage

// File: rtl/llm_level_detect.sv
module llm_level_detect
    import llm_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_valid,
    input  logic [PW-1:0] pwr_sample,
    input  logic [PW-1:0] pth,
    input  logic [PW-1:0] hyst,
    output pwr_cmp_t      cmp,
    output logic          below_q,
    output load_mode_e    mode_q
);
    localparam int UW = PW + 1;

    logic [UW-1:0] upper;

    always_comb begin
        upper          = {1'b0, pth} + {1'b0, hyst};
        cmp.under      = pwr_valid && (pwr_sample < pth);
        cmp.at_or_over = pwr_valid && (pwr_sample >= pth);
        cmp.above_band = pwr_valid && ({1'b0, pwr_sample} > upper);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_NORMAL;
            below_q <= 1'b0;
        end else begin
            if (cmp.under)
                mode_q <= MODE_LIGHT;
            else if (cmp.above_band)
                mode_q <= MODE_NORMAL;
            if (cmp.under)
                below_q <= 1'b1;
            else if (cmp.at_or_over)
                below_q <= 1'b0;
        end
    end

    a_r2_enter_light: assert property (@(posedge clk) disable iff (rst)
        (pwr_valid && pwr_sample < pth) |=> (mode_q == MODE_LIGHT));

    a_r3_leave_light: assert property (@(posedge clk) disable iff (rst)
        (pwr_valid && ({1'b0, pwr_sample} > ({1'b0, pth} + {1'b0, hyst})))
        |=> (mode_q == MODE_NORMAL));

    a_r3_hold_in_band: assert property (@(posedge clk) disable iff (rst)
        (pwr_valid && pwr_sample >= pth &&
         ({1'b0, pwr_sample} <= ({1'b0, pth} + {1'b0, hyst})))
        |=> $stable(mode_q));

    a_r3_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !pwr_valid |=> $stable(mode_q));

endmodule

// File: rtl/llm_filter_qual.sv
module llm_filter_qual
    import llm_pkg::*;
#(
    parameter int QUAL_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  pwr_cmp_t cmp,
    input  logic     below_q,
    input  logic     line_tick,
    output logic     filt_q
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(QUAL_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          below_now;

    // The sample in this cycle decides whether this cycle's tick counts
    assign below_now = cmp.under | (below_q & ~cmp.at_or_over);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            if (cmp.at_or_over)
                cnt_q <= '0;
            else if (line_tick && below_now)
                cnt_q <= CW'(sat_inc(int'(cnt_q), QUAL_CYCLES));

            if (cmp.above_band)
                filt_q <= 1'b0;
            else if (cnt_q == CNT_FULL)
                filt_q <= 1'b1;
        end
    end

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL);

    a_r6_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        cmp.at_or_over |=> (cnt_q == '0));

    a_r6_entry_qualified: assert property (@(posedge clk) disable iff (rst)
        $rose(filt_q) |-> ($past(cnt_q) == CNT_FULL));

    a_r7_fast_exit: assert property (@(posedge clk) disable iff (rst)
        cmp.above_band |=> !filt_q);

endmodule

// File: rtl/llm_out_gate.sv
module llm_out_gate
    import llm_pkg::*;
#(
    parameter int FW = 12
) (
    input  logic [5:3]    feat_en,
    input  load_mode_e    mode,
    input  logic          filt_state,
    input  logic [FW-1:0] f_norm,
    input  logic [FW-1:0] f_low,
    output logic          low_freq_sel,
    output logic          phase_shed,
    output logic          filt_light,
    output logic [FW-1:0] freq_word
);
    logic light;

    always_comb begin
        light        = (mode == MODE_LIGHT);
        low_freq_sel = feat_en[EN_FREQ] & light;
        phase_shed   = feat_en[EN_SHED] & light;
        filt_light   = feat_en[EN_FILT] & filt_state;
        freq_word    = low_freq_sel ? f_low : f_norm;
    end

endmodule

// File: rtl/llm_supervisor.sv
module llm_supervisor
    import llm_pkg::*;
#(
    parameter int PW          = 16,
    parameter int FW          = 12,
    parameter int QUAL_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_valid,
    input  logic [PW-1:0] pwr_sample,
    input  logic          line_tick,
    input  logic [5:3]    feat_en,
    input  logic [PW-1:0] pth,
    input  logic [PW-1:0] hyst,
    input  logic [FW-1:0] f_norm,
    input  logic [FW-1:0] f_low,
    output logic          low_freq_sel,
    output logic          phase_shed,
    output logic          filt_light,
    output logic [FW-1:0] freq_word
);
    pwr_cmp_t   cmp;
    logic       below_q;
    load_mode_e mode_q;
    logic       filt_q;

    llm_level_detect #(.PW(PW)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .pwr_valid  (pwr_valid),
        .pwr_sample (pwr_sample),
        .pth        (pth),
        .hyst       (hyst),
        .cmp        (cmp),
        .below_q    (below_q),
        .mode_q     (mode_q)
    );

    llm_filter_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .cmp       (cmp),
        .below_q   (below_q),
        .line_tick (line_tick),
        .filt_q    (filt_q)
    );

    llm_out_gate #(.FW(FW)) u_gate (
        .feat_en      (feat_en),
        .mode         (mode_q),
        .filt_state   (filt_q),
        .f_norm       (f_norm),
        .f_low        (f_low),
        .low_freq_sel (low_freq_sel),
        .phase_shed   (phase_shed),
        .filt_light   (filt_light),
        .freq_word    (freq_word)
    );

    a_r5_shed_follows_drop: assert property (@(posedge clk) disable iff (rst)
        (pwr_valid && pwr_sample < pth && feat_en[EN_SHED])
        |=> (phase_shed || !feat_en[EN_SHED]));

    a_r4_freq_on_drop: assert property (@(posedge clk) disable iff (rst)
        (pwr_valid && pwr_sample < pth)
        |=> (!feat_en[EN_FREQ] || freq_word == f_low));

endmodule

// File: tb/llm_supervisor_bench.sv
`timescale 1ns/1ps
module llm_supervisor_bench;
    localparam int PW = 16;
    localparam int FW = 12;
    localparam int QN = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_valid = 1'b0;
    logic [PW-1:0] pwr_sample = '0;
    logic          line_tick = 1'b0;
    logic [5:3]    feat_en = 3'b111;
    logic [PW-1:0] pth = 16'd1000;
    logic [PW-1:0] hyst = 16'd200;
    logic [FW-1:0] f_norm = 12'd100;
    logic [FW-1:0] f_low = 12'd40;
    logic          low_freq_sel, phase_shed, filt_light;
    logic [FW-1:0] freq_word;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string req = "R1";

    // reference model state
    int m_light = 0, m_below = 0, m_cnt = 0, m_filt = 0;

    always #2.5 clk = ~clk;

    llm_supervisor #(.PW(PW), .FW(FW), .QUAL_CYCLES(QN)) u_llm_supervisor (
        .clk(clk), .rst(rst), .pwr_valid(pwr_valid), .pwr_sample(pwr_sample),
        .line_tick(line_tick), .feat_en(feat_en), .pth(pth), .hyst(hyst),
        .f_norm(f_norm), .f_low(f_low), .low_freq_sel(low_freq_sel),
        .phase_shed(phase_shed), .filt_light(filt_light), .freq_word(freq_word)
    );

    always @(posedge clk) begin
        int s, lo, hi, prev_cnt;
        cycles++;
        if (rst) begin
            m_light = 0; m_below = 0; m_cnt = 0; m_filt = 0;
        end else begin
            s = int'(pwr_sample);
            lo = int'(pth);
            hi = int'(pth) + int'(hyst);
            prev_cnt = m_cnt;
            if (pwr_valid) begin
                if (s < lo) m_light = 1;
                else if (s > hi) m_light = 0;
                m_below = (s < lo) ? 1 : 0;
            end
            if (pwr_valid && s >= lo) m_cnt = 0;
            else if (line_tick && m_below == 1) m_cnt = (m_cnt < QN) ? m_cnt + 1 : QN;
            if (pwr_valid && s > hi) m_filt = 0;
            else if (prev_cnt == QN) m_filt = 1;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int e_low, e_shed, e_filt, e_freq;
        e_low  = (feat_en[3] && m_light == 1) ? 1 : 0;
        e_shed = (feat_en[4] && m_light == 1) ? 1 : 0;
        e_filt = (feat_en[5] && m_filt == 1) ? 1 : 0;
        e_freq = (e_low == 1) ? int'(f_low) : int'(f_norm);
        chk("low_freq_sel (R4)", int'(low_freq_sel), e_low);
        chk("phase_shed (R5)", int'(phase_shed), e_shed);
        chk("filt_light (R6/R7)", int'(filt_light), e_filt);
        chk("freq_word (R4)", int'(freq_word), e_freq);
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic sample(int v);
        pwr_valid = 1'b1; pwr_sample = PW'(v);
        step(1);
        pwr_valid = 1'b0;
        step(1);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            line_tick = 1'b1; step(1);
            line_tick = 1'b0; step(2);
        end
    endtask

    initial begin
        fork
            begin
                // R1: reset state
                step(4);
                rst = 1'b0;
                step(2);
                // R2, R3: entry, band hold, strict comparisons
                req = "R2"; sample(1500); sample(999);
                req = "R3"; sample(1000); sample(1200); sample(1201);
                sample(1000); sample(999);
                // R6: qualification, partial runs, saturation
                req = "R6"; ticks(3); step(2); ticks(1); step(2); ticks(3);
                // R7: in-band sample holds filter, exit above band clears it
                req = "R7"; sample(1100); ticks(2); sample(1200); sample(1201);
                // R6: broken run restarts count
                req = "R6"; sample(500); ticks(2); sample(1050); sample(500);
                ticks(3); ticks(1); ticks(2);
                // strobe and tick together; unstrobed out-of-range samples ignored (R3)
                req = "R3";
                pwr_valid = 1'b0; pwr_sample = 16'd60000; line_tick = 1'b1; step(1);
                line_tick = 1'b0; step(2);
                pwr_valid = 1'b1; pwr_sample = 16'd1300; line_tick = 1'b1; step(1);
                pwr_valid = 1'b0; line_tick = 1'b0; step(2);
                pwr_valid = 1'b1; pwr_sample = 16'd10; line_tick = 1'b1; step(1);
                pwr_valid = 1'b0; line_tick = 1'b0; step(2);
                ticks(4);
                // R8: enables gate outputs, state continues underneath
                req = "R8";
                feat_en = 3'b000; step(3);
                feat_en = 3'b001; step(2);
                feat_en = 3'b010; step(2);
                feat_en = 3'b100; step(2);
                feat_en = 3'b000; sample(2000); sample(300); ticks(5);
                feat_en = 3'b111; step(3);
                f_low = 12'd7; step(2);
                // R9: threshold plus hysteresis beyond sample range
                req = "R9";
                pth = 16'd60000; hyst = 16'd10000; sample(65535); sample(59999);
                sample(65535); ticks(4); sample(65535);
                hyst = 16'd5534; sample(65535);
                hyst = 16'd5535; sample(50000); sample(65535);
                // R1: reset in light load
                req = "R1";
                sample(10); ticks(5);
                rst = 1'b1; step(2); rst = 1'b0; step(3);
            end
            begin
                while (cycles < 100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule